// File: doc/BRIEF.md
# ACPI Fixed Event and Control Registers

This block holds the fixed ACPI power-management registers behind a byte-addressed I/O bus: an event status word, an event enable word and a control word. It also has two byte-wide ports. A write-only command port switches ACPI mode on and off. A reset port asks for a system restart. The block drives the level-sensitive system control interrupt (SCI). It turns a power-button event into a status flag, and it issues one-cycle requests for soft power-off and system reset.

Software sets the enable bits and clears pending flags by writing ones to them. It requests soft-off by writing the control word with the sleep-go bit set and a sleep type of 5. Bus reads are combinational: the read data reflects the addressed register while the read strobe is high. The register bases and the two command codes are parameters.

Top module: `pm_fixed_regs`

## Requirements
- R1: The status word is at EVT_BASE, the enable word at EVT_BASE+2 and the control word at CNT_BASE. All three accept only 2-byte accesses (busBytes=2). The command port (SMI_PORT) and the reset port (RST_PORT) accept only 1-byte accesses (busBytes=1). A write with any other byte count has no effect. A read with the wrong byte count, a read of the command port and a read of an unmapped address all return 16'hFFFF.
- R2: A status write clears bit i only where the written data has bit i set and i is one of 15, 10, 9, 8 or 4. Every other status bit keeps its value.
- R3: An enable write stores only bits 8 and 5 of the data. All other enable bits read back as 0.
- R4: sciOut is high exactly while some bit i in {0, 5, 8, 9, 10} is set in both status and enable. It follows a register change in the same cycle in which the new value is held.
- R5: While control bit 0 is 1, a power-button event (pwrBtnEvt high at a clock edge) sets status bit 8. If a write that clears bit 8 arrives on the same edge, the event wins. While control bit 0 is 0, events are ignored.
- R6: A control write stores (old & 16'h0001) | (data & ~16'hE003). Bit 0 is kept, and bits 15, 14, 13, 1 and 0 of the data are dropped.
- R7: A 1-byte command write of CMD_ON sets control bit 0. CMD_OFF clears it. Any other code changes nothing.
- R8: A control write whose data has bit 13 set and bits 12:10 equal to 5 makes powerOffReq high for exactly the one cycle after the write edge. No other control write raises it.
- R9: The reset port reads back the last byte written to it, in bits 7:0 with bits 15:8 zero. A write with data bit 2 set makes sysResetReq high for exactly one cycle after the write edge, whatever the value of bit 1.
- R10: After reset all registers are 0, and sciOut, powerOffReq and sysResetReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | I/O address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busBytes | input | 3 | Access byte count |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, combinational |
| pwrBtnEvt | input | 1 | Power-button event |
| sciOut | output | 1 | Level SCI line |
| powerOffReq | output | 1 | One-cycle soft-off request |
| sysResetReq | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach is a power-button event on the same edge as a status write that clears bit 8. Only that edge exercises the rule that the event wins. The bench first arms the input through the command port. It then raises pwrBtnEvt in the same half-cycle in which it launches the clearing write, and it reads the status back afterwards. Gating of SCI is checked by sweeping the enable word between the power-button bit and the global bit while the power-button flag is pending.

// File: rtl/pm_fixed_pkg.sv
package pm_fixed_pkg;
  localparam int REG_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [REG_W-1:0] STAT_CLEARABLE = 16'h8710;
  localparam logic [REG_W-1:0] ENA_WRITABLE   = 16'h0120;
  localparam logic [REG_W-1:0] SCI_SOURCES    = 16'h0721;
  localparam logic [REG_W-1:0] CNT_DROPPED    = 16'hE003;

  localparam int ACPI_ON_BIT    = 0;
  localparam int PWR_BTN_BIT    = 8;
  localparam int SLEEP_GO_BIT   = 13;
  localparam int SLEEP_KIND_LSB = 10;
  localparam int SLEEP_KIND_W   = 3;
  localparam logic [SLEEP_KIND_W-1:0] SOFT_OFF_KIND = 3'd5;
  localparam int RESTART_BIT    = 2;

  typedef struct packed {
    logic wrStat;
    logic wrEna;
    logic wrCnt;
    logic wrCmd;
    logic wrRst;
  } pmStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STAT,
    RD_ENA,
    RD_CNT,
    RD_RST
  } pmRdSel_t;
endpackage

// File: rtl/pm_fixed_ctrl.sv
module pm_fixed_ctrl
  import pm_fixed_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] EVT_BASE = 16'h0400,
  parameter logic [ADDR_W-1:0] CNT_BASE = 16'h0404,
  parameter logic [ADDR_W-1:0] SMI_PORT = 16'h00B2,
  parameter logic [ADDR_W-1:0] RST_PORT = 16'h0CF9
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [2:0]        busBytes,
  output pmStrobe_t         stb,
  output pmRdSel_t          rdSel
);
  localparam logic [ADDR_W-1:0] ENA_ADDR = ADDR_W'(EVT_BASE + 2);

  logic wide, narrow;
  logic hitStat, hitEna, hitCnt, hitCmd, hitRst;

  always_comb begin
    wide    = (busBytes == 3'd2);
    narrow  = (busBytes == 3'd1);
    hitStat = (busAddr == EVT_BASE);
    hitEna  = (busAddr == ENA_ADDR);
    hitCnt  = (busAddr == CNT_BASE);
    hitCmd  = (busAddr == SMI_PORT);
    hitRst  = (busAddr == RST_PORT);
  end

  always_comb begin
    stb.wrStat = busWr & hitStat & wide;
    stb.wrEna  = busWr & hitEna & wide;
    stb.wrCnt  = busWr & hitCnt & wide;
    stb.wrCmd  = busWr & hitCmd & narrow;
    stb.wrRst  = busWr & hitRst & narrow;
  end

  always_comb begin
    rdSel = RD_NONE;
    if (busRd) begin
      if (hitStat && wide)     rdSel = RD_STAT;
      else if (hitEna && wide) rdSel = RD_ENA;
      else if (hitCnt && wide) rdSel = RD_CNT;
      else if (hitRst && narrow) rdSel = RD_RST;
    end
  end
endmodule

// File: rtl/pm_fixed_dp.sv
module pm_fixed_dp
  import pm_fixed_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CMD_ON  = 8'hA0,
  parameter logic [BYTE_W-1:0] CMD_OFF = 8'hA1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmStrobe_t         stb,
  input  logic [REG_W-1:0]  wrData,
  input  logic              pwrBtnEvt,
  output logic [REG_W-1:0]  statQ,
  output logic [REG_W-1:0]  enaQ,
  output logic [REG_W-1:0]  cntQ,
  output logic [BYTE_W-1:0] rstByteQ,
  output logic              sciOut,
  output logic              powerOffReq,
  output logic              sysResetReq
);
  logic [REG_W-1:0] clearMask;
  logic [REG_W-1:0] statNext;
  logic [REG_W-1:0] cntNext;
  logic [REG_W-1:0] pending;
  logic             btnSet;
  logic             offHit;

  assign btnSet = pwrBtnEvt & cntQ[ACPI_ON_BIT];

  // per-bit status update: clearable bits obey write-one-to-clear
  for (genvar i = 0; i < REG_W; i++) begin : g_stat
    if (STAT_CLEARABLE[i]) begin : g_clr
      assign clearMask[i] = stb.wrStat & wrData[i];
    end else begin : g_keep
      assign clearMask[i] = 1'b0;
    end
    if (i == PWR_BTN_BIT) begin : g_btn
      assign statNext[i] = btnSet | (statQ[i] & ~clearMask[i]);
    end else begin : g_plain
      assign statNext[i] = statQ[i] & ~clearMask[i];
    end
  end

  always_comb begin
    cntNext = cntQ;
    if (stb.wrCnt) begin
      cntNext = (cntQ & (REG_W'(1) << ACPI_ON_BIT)) | (wrData & ~CNT_DROPPED);
    end else if (stb.wrCmd) begin
      if (wrData[BYTE_W-1:0] == CMD_ON)       cntNext[ACPI_ON_BIT] = 1'b1;
      else if (wrData[BYTE_W-1:0] == CMD_OFF) cntNext[ACPI_ON_BIT] = 1'b0;
    end
  end

  assign offHit = stb.wrCnt & wrData[SLEEP_GO_BIT] &
                  (wrData[SLEEP_KIND_LSB +: SLEEP_KIND_W] == SOFT_OFF_KIND);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ       <= '0;
      enaQ        <= '0;
      cntQ        <= '0;
      rstByteQ    <= '0;
      powerOffReq <= 1'b0;
      sysResetReq <= 1'b0;
    end else begin
      statQ       <= statNext;
      cntQ        <= cntNext;
      if (stb.wrEna) enaQ <= wrData & ENA_WRITABLE;
      if (stb.wrRst) rstByteQ <= wrData[BYTE_W-1:0];
      powerOffReq <= offHit;
      sysResetReq <= stb.wrRst & wrData[RESTART_BIT];
    end
  end

  assign pending = statQ & enaQ & SCI_SOURCES;
  assign sciOut  = |pending;
endmodule

// File: rtl/pm_fixed_regs.sv
module pm_fixed_regs
  import pm_fixed_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] EVT_BASE = 16'h0400,
  parameter logic [ADDR_W-1:0] CNT_BASE = 16'h0404,
  parameter logic [ADDR_W-1:0] SMI_PORT = 16'h00B2,
  parameter logic [ADDR_W-1:0] RST_PORT = 16'h0CF9,
  parameter logic [7:0] CMD_ON  = 8'hA0,
  parameter logic [7:0] CMD_OFF = 8'hA1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [2:0]        busBytes,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData,
  input  logic              pwrBtnEvt,
  output logic              sciOut,
  output logic              powerOffReq,
  output logic              sysResetReq
);
  pmStrobe_t         stb;
  pmRdSel_t          rdSel;
  logic [REG_W-1:0]  statQ, enaQ, cntQ;
  logic [BYTE_W-1:0] rstByteQ;

  pm_fixed_ctrl #(
    .ADDR_W(ADDR_W), .EVT_BASE(EVT_BASE), .CNT_BASE(CNT_BASE),
    .SMI_PORT(SMI_PORT), .RST_PORT(RST_PORT)
  ) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busBytes(busBytes),
    .stb(stb), .rdSel(rdSel)
  );

  pm_fixed_dp #(.CMD_ON(CMD_ON), .CMD_OFF(CMD_OFF)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData),
    .pwrBtnEvt(pwrBtnEvt), .statQ(statQ), .enaQ(enaQ), .cntQ(cntQ),
    .rstByteQ(rstByteQ), .sciOut(sciOut), .powerOffReq(powerOffReq),
    .sysResetReq(sysResetReq)
  );

  always_comb begin
    case (rdSel)
      RD_STAT: busRdData = statQ;
      RD_ENA:  busRdData = enaQ;
      RD_CNT:  busRdData = cntQ;
      RD_RST:  busRdData = {{(REG_W-BYTE_W){1'b0}}, rstByteQ};
      default: busRdData = '1;
    endcase
  end
endmodule

// File: rtl/pm_fixed_chk.sv
module pm_fixed_chk
  import pm_fixed_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input pmStrobe_t        stb,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] ena,
  input logic             statBtn,
  input logic             acpiOn,
  input logic             pwrBtnEvt,
  input logic             sciOut,
  input logic             powerOffReq,
  input logic             sysResetReq
);
  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  assert_ena_stored_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEna |=> (ena == ($past(wrData) & ENA_WRITABLE)));

  assert_sci_needs_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
    sciOut |-> (ena != '0));

  assert_btn_armed_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statBtn) |-> $past(pwrBtnEvt && acpiOn));

  assert_acpi_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCnt |=> (acpiOn == $past(acpiOn)));

  assert_off_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |=> !powerOffReq);

  assert_off_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |-> $past(stb.wrCnt && wrData[SLEEP_GO_BIT]));

  assert_rst_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> !sysResetReq);

  assert_rst_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(stb.wrRst && wrData[RESTART_BIT]));
endmodule

bind pm_fixed_regs pm_fixed_chk u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .ena(enaQ),
  .statBtn(statQ[8]), .acpiOn(cntQ[0]), .pwrBtnEvt(pwrBtnEvt),
  .sciOut(sciOut), .powerOffReq(powerOffReq), .sysResetReq(sysResetReq)
);

// File: tb/sim_pm_fixed_regs.sv
module sim_pm_fixed_regs;
  localparam logic [15:0] EVT = 16'h0400;
  localparam logic [15:0] CNT = 16'h0404;
  localparam logic [15:0] CMD = 16'h00B2;
  localparam logic [15:0] RST = 16'h0CF9;
  localparam logic [7:0]  ON  = 8'hA0;
  localparam logic [7:0]  OFF = 8'hA1;

  logic clk = 0, rstN = 0;
  logic [15:0] busAddr = 0, busWrData = 0, busRdData;
  logic busWr = 0, busRd = 0, pwrBtnEvt = 0;
  logic [2:0] busBytes = 0;
  logic sciOut, powerOffReq, sysResetReq;
  int checks = 0, errors = 0;
  logic done = 0;

  always #4 clk = ~clk;

  pm_fixed_regs u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busBytes(busBytes), .busWrData(busWrData), .busRdData(busRdData),
    .pwrBtnEvt(pwrBtnEvt), .sciOut(sciOut), .powerOffReq(powerOffReq),
    .sysResetReq(sysResetReq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [2:0] n, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busBytes = n; busWrData = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [2:0] n, output logic [15:0] d);
    busAddr = a; busBytes = n; busRd = 1;
    #1 d = busRdData;
    busRd = 0;
  endtask

  task automatic button();
    @(negedge clk); pwrBtnEvt = 1;
    @(negedge clk); pwrBtnEvt = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R10: reset state
    rd(EVT, 2, v); check("R10 status", v, 16'h0);
    rd(EVT + 2, 2, v); check("R10 enable", v, 16'h0);
    rd(CNT, 2, v); check("R10 control", v, 16'h0);
    rd(RST, 1, v); check("R10 reset port", v, 16'h0);
    check("R10 outputs", {13'h0, sciOut, powerOffReq, sysResetReq}, 16'h0);

    // R1: decode and size rules
    rd(EVT, 1, v); check("R1 wrong size read", v, 16'hFFFF);
    rd(CNT, 4, v); check("R1 wrong size read ctl", v, 16'hFFFF);
    rd(16'h0300, 2, v); check("R1 unmapped read", v, 16'hFFFF);
    rd(CMD, 1, v); check("R1 command port read", v, 16'hFFFF);
    wr(EVT + 2, 1, 16'h0120); rd(EVT + 2, 2, v); check("R1 wrong size write ena", v, 16'h0);
    wr(RST, 2, 16'h0004);
    check("R1 wrong size reset pulse", {15'h0, sysResetReq}, 16'h0);
    rd(RST, 1, v); check("R1 wrong size reset data", v, 16'h0);
    wr(CMD, 2, {8'h0, ON}); rd(CNT, 2, v); check("R1 wrong size command", v, 16'h0);

    // R3: enable write mask sweep
    for (int b = 0; b < 16; b++) begin
      wr(EVT + 2, 2, 16'h1 << b);
      rd(EVT + 2, 2, v);
      check("R3 enable mask", v, (16'h1 << b) & 16'h0120);
    end
    wr(EVT + 2, 2, 16'h0);

    // R6 / R8: control writes across every sleep kind
    wr(CNT, 2, 16'hFFFF);
    check("R8 kind 7 no pulse", {15'h0, powerOffReq}, 16'h0);
    rd(CNT, 2, v); check("R6 control mask", v, 16'h1FFC);
    for (int t = 0; t < 8; t++) begin
      wr(CNT, 2, 16'h2000 | 16'(t << 10));
      check("R8 pulse by kind", {15'h0, powerOffReq}, (t == 5) ? 16'h1 : 16'h0);
      rd(CNT, 2, v); check("R6 kind stored", v, 16'(t << 10));
      @(negedge clk);
      check("R8 pulse one cycle", {15'h0, powerOffReq}, 16'h0);
    end
    wr(CNT, 2, 16'h1400);
    check("R8 no go bit", {15'h0, powerOffReq}, 16'h0);

    // R7: command code sweep
    for (int c = 0; c < 256; c++) begin
      wr(CMD, 1, 16'(c));
      rd(CNT, 2, v);
      check("R7 command code", {15'h0, v[0]}, (8'(c) == ON) ? 16'h1 : 16'h0);
      if (v[0]) begin
        wr(CMD, 1, {8'h0, OFF});
        rd(CNT, 2, v); check("R7 disable code", {15'h0, v[0]}, 16'h0);
      end
    end

    // R6: control write keeps the ACPI-on bit
    wr(CMD, 1, {8'h0, ON});
    wr(CNT, 2, 16'h0000); rd(CNT, 2, v); check("R6 keep on", v, 16'h0001);
    wr(CMD, 1, {8'h0, OFF});
    wr(CNT, 2, 16'h0001); rd(CNT, 2, v); check("R6 keep off", v, 16'h0000);

    // R5: button disarmed then armed
    button(); rd(EVT, 2, v); check("R5 disarmed ignored", v, 16'h0);
    wr(CMD, 1, {8'h0, ON});
    button(); rd(EVT, 2, v); check("R5 armed sets", v, 16'h0100);

    // R4: SCI gating
    check("R4 no enable", {15'h0, sciOut}, 16'h0);
    wr(EVT + 2, 2, 16'h0100); check("R4 enabled pending", {15'h0, sciOut}, 16'h1);
    wr(EVT + 2, 2, 16'h0020); check("R4 other enable", {15'h0, sciOut}, 16'h0);
    wr(EVT + 2, 2, 16'h0100); check("R4 re-enabled", {15'h0, sciOut}, 16'h1);

    // R2: write-one-to-clear
    wr(EVT, 2, 16'hFEFF); rd(EVT, 2, v); check("R2 other ones keep", v, 16'h0100);
    check("R4 still pending", {15'h0, sciOut}, 16'h1);
    wr(EVT, 2, 16'h0100); rd(EVT, 2, v); check("R2 clear bit 8", v, 16'h0);
    check("R4 cleared", {15'h0, sciOut}, 16'h0);

    // R5: event beats a simultaneous clear
    @(negedge clk);
    pwrBtnEvt = 1; busAddr = EVT; busBytes = 2; busWrData = 16'h0100; busWr = 1;
    @(negedge clk);
    pwrBtnEvt = 0; busWr = 0;
    rd(EVT, 2, v); check("R5 event wins", v, 16'h0100);
    wr(EVT, 2, 16'hFFFF); rd(EVT, 2, v); check("R2 clear all", v, 16'h0);

    // R9: reset port sweep
    for (int r = 0; r < 256; r++) begin
      wr(RST, 1, 16'(r));
      check("R9 restart pulse", {15'h0, sysResetReq}, 16'(r >> 2) & 16'h1);
      rd(RST, 1, v); check("R9 readback", v, 16'(r));
      @(negedge clk);
      check("R9 pulse one cycle", {15'h0, sysResetReq}, 16'h0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule